// File: doc/BRIEF.md
# Binary64 Round-and-Pack Unit

This block is the last step of a double-precision datapath. It receives an unrounded intermediate value, made of a sign, a signed biased exponent and a normalised significand that keeps ten guard bits below the final fraction LSB. It picks a round increment from the requested rounding mode and adds it at the guard bits. If the addition carries out of the significand, it renormalises. It then packs the result into a binary64 word with three flags: inexact, overflow and underflow.

Besides nearest-even, ties-away and the three directed modes, the unit offers a round-to-odd mode. When a result is not exact, this mode keeps the truncated magnitude and forces its LSB to 1. Such a result can later be rounded again to a narrower format without double-rounding error. Results too large for the format become infinity or the largest finite magnitude, depending on the mode. Results too small for a normal number are flushed to a signed zero. No subnormal output is produced.

Input and output are valid/ready streams with a single register stage. A transfer happens on any clock edge where valid and ready are both high. The upstream may present a new operand on every cycle, and one result leaves per cycle. When `out_ready` is low while `out_valid` is high, the result word and flags stay frozen and `in_ready` drops, so nothing is accepted until the stalled result is taken.

Top module: `fp_round_pack`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or is being drained this cycle. An accepted operand appears with `out_valid` high on the next cycle. A result held under `out_ready` low keeps its word and flags unchanged.
- R2: The output word puts the sign at bit 63, the 11-bit exponent at bits 62:52 and the fraction at bits 51:0. The input significand has its leading one at bit 62, the fraction at bits 61:10 and guard bits at 9:0. The leading one is dropped when packing.
- R3: Mode 0 (nearest-even) rounds up when the guard bits exceed 0x200 and truncates when they are below 0x200. On exactly 0x200 it picks the neighbour with an even fraction. Modes 6 and 7 behave as mode 0.
- R4: Mode 4 (ties-away) rounds up when the guard bits are 0x200 or more, and truncates otherwise.
- R5: Mode 1 rounds toward minus infinity, mode 2 toward plus infinity and mode 3 toward zero. A magnitude is bumped by one LSB only when the guard bits are nonzero and the mode's direction moves away from zero for the operand's sign.
- R6: Mode 5 (round-to-odd) returns an exact value unchanged. For an inexact value it returns the truncated fraction with its LSB forced to 1.
- R7: When rounding carries out of the significand, the fraction becomes zero and the exponent increases by one.
- R8: A rounded exponent of 2047 or more sets overflow and inexact. The result is infinity (exponent all ones, fraction zero) in modes 0, 4, 6 and 7, in mode 2 for a positive sign and in mode 1 for a negative sign. In all other cases it is the largest finite magnitude (exponent 0x7FE, fraction all ones) with the operand's sign.
- R9: A rounded exponent below 1 gives a zero with the operand's sign, and sets underflow and inexact. The test uses the exponent after any carry from R7.
- R10: In range, inexact is set exactly when the guard bits are nonzero, and overflow and underflow are clear.
- R11: While `rst_n` is low, `out_valid` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can take an operand |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | 13 | Signed biased exponent |
| in_sig | input | 63 | Normalised significand with 10 guard bits |
| in_mode | input | 3 | Rounding mode code |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_word | output | 64 | Packed binary64 result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
The assertions assume that operands arrive normalised, with bit 62 of `in_sig` set. They also assume that `in_exp` stays well inside its signed range, so that adding the carry bit cannot wrap it. The round-to-odd property also relies on this: with a normalised significand, an exponent between 1 and 2046 cannot overflow in that mode. Every stimulus vector sets bit 62 and uses exponents between -16 and 0x900, which satisfies both assumptions. The flow-control checks hold `out_ready` low across several edges while a second operand waits at the input.

// File: rtl/fprp_pkg.sv
`timescale 1ns/1ps
package fprp_pkg;
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_DOWN      = 3'd1,
    RM_UP        = 3'd2,
    RM_ZERO      = 3'd3,
    RM_TIES_AWAY = 3'd4,
    RM_ODD       = 3'd5,
    RM_RSV6      = 3'd6,
    RM_RSV7      = 3'd7
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
  } fp_flags_t;

  function automatic logic is_nearest(rmode_e m);
    return (m == RM_NEAR_EVEN) || (m == RM_RSV6) || (m == RM_RSV7);
  endfunction
endpackage

// File: rtl/fprp_incr.sv
`timescale 1ns/1ps
module fprp_incr #(
  parameter int GRD_W = 10
) (
  input  fprp_pkg::rmode_e   mode,
  input  logic               sign,
  input  logic               lsb,
  output logic [GRD_W-1:0]   inc,
  output logic               even_fix
);
  import fprp_pkg::*;
  localparam logic [GRD_W-1:0] HALF = GRD_W'(1) << (GRD_W-1);
  localparam logic [GRD_W-1:0] FULL = '1;

  always_comb begin
    inc      = '0;
    even_fix = 1'b0;
    unique case (mode)
      RM_DOWN:      inc = sign ? FULL : '0;
      RM_UP:        inc = sign ? '0 : FULL;
      RM_ZERO:      inc = '0;
      RM_TIES_AWAY: inc = HALF;
      RM_ODD:       inc = lsb ? '0 : FULL;
      default: begin
        inc      = HALF;
        even_fix = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fprp_round.sv
`timescale 1ns/1ps
module fprp_round #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int GRD_W  = 10
) (
  input  logic [FRAC_W+GRD_W:0]    sig,
  input  logic signed [EXP_W+1:0]  exp_in,
  input  logic [GRD_W-1:0]         inc,
  input  logic                     even_fix,
  output logic [FRAC_W-1:0]        frac,
  output logic signed [EXP_W+1:0]  exp_out,
  output logic                     inexact
);
  localparam int UP_W = FRAC_W + 1;

  logic [GRD_W-1:0] guard;
  logic [UP_W-1:0]  upper;
  logic [GRD_W:0]   gsum;
  logic             cin;
  logic [UP_W:0]    usum;
  logic             carry;
  logic             tie_hit;
  logic [FRAC_W-1:0] frac_raw;

  assign guard   = sig[GRD_W-1:0];
  assign upper   = sig[FRAC_W+GRD_W:GRD_W];
  assign gsum    = {1'b0, guard} + {1'b0, inc};
  assign cin     = gsum[GRD_W];
  assign usum    = {1'b0, upper} + {{UP_W{1'b0}}, cin};
  assign carry   = usum[UP_W];
  assign tie_hit = even_fix && (gsum[GRD_W-1:0] == '0);
  assign inexact = |guard;

  assign frac_raw = carry ? usum[FRAC_W:1] : usum[FRAC_W-1:0];

  always_comb begin
    frac = frac_raw;
    if (tie_hit) frac[0] = 1'b0;
  end

  assign exp_out = exp_in + $signed({{(EXP_W+1){1'b0}}, carry});
endmodule

// File: rtl/fprp_pack.sv
`timescale 1ns/1ps
module fprp_pack #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  fprp_pkg::rmode_e          mode,
  input  logic                      sign,
  input  logic signed [EXP_W+1:0]   exp_r,
  input  logic [FRAC_W-1:0]         frac,
  input  logic                      inexact,
  output logic [EXP_W+FRAC_W:0]     word,
  output fprp_pkg::fp_flags_t       flags
);
  import fprp_pkg::*;
  localparam logic signed [EXP_W+1:0] EXP_TOP = (1 <<< EXP_W) - 1;
  localparam logic signed [EXP_W+1:0] EXP_MIN = 1;

  logic ovf, unf, to_inf;

  assign ovf = exp_r >= EXP_TOP;
  assign unf = exp_r < EXP_MIN;
  assign to_inf = is_nearest(mode) || (mode == RM_TIES_AWAY) ||
                  ((mode == RM_UP) && !sign) || ((mode == RM_DOWN) && sign);

  always_comb begin
    flags = '{ovf: 1'b0, unf: 1'b0, inx: inexact};
    word  = {sign, exp_r[EXP_W-1:0], frac};
    if (ovf) begin
      flags.ovf = 1'b1;
      flags.inx = 1'b1;
      if (to_inf) word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else        word = {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else if (unf) begin
      flags.unf = 1'b1;
      flags.inx = 1'b1;
      word = {sign, {(EXP_W+FRAC_W){1'b0}}};
    end
  end
endmodule

// File: rtl/fprp_stage.sv
`timescale 1ns/1ps
module fprp_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/fp_round_pack.sv
`timescale 1ns/1ps
module fp_round_pack #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int GRD_W  = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_sign,
  input  logic signed [EXP_W+1:0]      in_exp,
  input  logic [FRAC_W+GRD_W:0]        in_sig,
  input  logic [2:0]                   in_mode,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [EXP_W+FRAC_W:0]        out_word,
  output logic                         out_ovf,
  output logic                         out_unf,
  output logic                         out_inx
);
  import fprp_pkg::*;
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int DW     = WORD_W + 3;

  rmode_e                  mode;
  logic [GRD_W-1:0]        inc;
  logic                    even_fix;
  logic [FRAC_W-1:0]       frac;
  logic signed [EXP_W+1:0] exp_r;
  logic                    inexact;
  logic [WORD_W-1:0]       word_d;
  fp_flags_t               flags_d;
  logic [DW-1:0]           q;

  assign mode = rmode_e'(in_mode);

  fprp_incr #(.GRD_W(GRD_W)) u_incr (
    .mode(mode), .sign(in_sign), .lsb(in_sig[GRD_W]),
    .inc(inc), .even_fix(even_fix)
  );

  fprp_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRD_W(GRD_W)) u_round (
    .sig(in_sig), .exp_in(in_exp), .inc(inc), .even_fix(even_fix),
    .frac(frac), .exp_out(exp_r), .inexact(inexact)
  );

  fprp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .mode(mode), .sign(in_sign), .exp_r(exp_r), .frac(frac),
    .inexact(inexact), .word(word_d), .flags(flags_d)
  );

  fprp_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data({word_d, flags_d}),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(q)
  );

  assign out_word = q[DW-1:3];
  assign out_ovf  = q[2];
  assign out_unf  = q[1];
  assign out_inx  = q[0];
endmodule

// File: rtl/fp_round_pack_chk.sv
`timescale 1ns/1ps
module fp_round_pack_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int GRD_W  = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic signed [EXP_W+1:0] in_exp,
  input logic [FRAC_W+GRD_W:0]   in_sig,
  input logic [2:0]              in_mode,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [EXP_W+FRAC_W:0]   out_word,
  input logic                    out_ovf,
  input logic                    out_unf,
  input logic                    out_inx
);
  localparam logic signed [EXP_W+1:0] EXP_HI = (1 <<< EXP_W) - 2;
  localparam logic signed [EXP_W+1:0] EXP_LO = 1;

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) &&
    $stable(out_ovf) && $stable(out_unf) && $stable(out_inx));

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  ovf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_inx && !out_unf);

  // R8
  exp_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (&out_word[EXP_W+FRAC_W-1:FRAC_W]) |->
    out_ovf && (out_word[FRAC_W-1:0] == '0));

  // R9
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> out_inx && (out_word[EXP_W+FRAC_W-1:0] == '0));

  // R6
  odd_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == 3'd5 && (|in_sig[GRD_W-1:0]) &&
    in_exp >= EXP_LO && in_exp <= EXP_HI |=> out_word[0]);

  // R11
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

bind fp_round_pack fp_round_pack_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRD_W(GRD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
);

// File: tb/sim_fp_round_pack.sv
`timescale 1ns/1ps
module sim_fp_round_pack;
  typedef struct packed {
    logic [2:0]  mode;
    logic        sgn;
    logic [12:0] ex;
    logic [51:0] f;
    logic [9:0]  g;
    logic [10:0] we;
    logic [51:0] wf;
    logic [2:0]  fl;   // {ovf, unf, inx}
    logic [7:0]  req;
  } vec_t;

  localparam logic [51:0] ONES = '1;
  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    // R2 exact pack
    '{3'd0, 1'b0, 13'h3FF, 52'h123456789ABCD, 10'h000, 11'h3FF, 52'h123456789ABCD, 3'b000, 8'd2},
    // R3 below half
    '{3'd0, 1'b1, 13'h400, 52'h5, 10'h1FF, 11'h400, 52'h5, 3'b001, 8'd3},
    // R3 above half
    '{3'd0, 1'b0, 13'h400, 52'h5, 10'h201, 11'h400, 52'h6, 3'b001, 8'd3},
    // R3 tie, even stays
    '{3'd0, 1'b0, 13'h400, 52'h4, 10'h200, 11'h400, 52'h4, 3'b001, 8'd3},
    // R3 tie, odd goes up
    '{3'd0, 1'b0, 13'h400, 52'h5, 10'h200, 11'h400, 52'h6, 3'b001, 8'd3},
    // R4 tie away
    '{3'd4, 1'b0, 13'h400, 52'h4, 10'h200, 11'h400, 52'h5, 3'b001, 8'd4},
    // R4 below half
    '{3'd4, 1'b1, 13'h400, 52'h4, 10'h1FF, 11'h400, 52'h4, 3'b001, 8'd4},
    // R5 down, positive
    '{3'd1, 1'b0, 13'h400, 52'h7, 10'h3FF, 11'h400, 52'h7, 3'b001, 8'd5},
    // R5 down, negative
    '{3'd1, 1'b1, 13'h400, 52'h7, 10'h001, 11'h400, 52'h8, 3'b001, 8'd5},
    // R5 up, positive
    '{3'd2, 1'b0, 13'h400, 52'h7, 10'h001, 11'h400, 52'h8, 3'b001, 8'd5},
    // R5 up, negative
    '{3'd2, 1'b1, 13'h400, 52'h7, 10'h3FF, 11'h400, 52'h7, 3'b001, 8'd5},
    // R5 toward zero
    '{3'd3, 1'b0, 13'h400, 52'h7, 10'h3FF, 11'h400, 52'h7, 3'b001, 8'd5},
    // R6 odd, even LSB forced
    '{3'd5, 1'b0, 13'h400, 52'h4, 10'h001, 11'h400, 52'h5, 3'b001, 8'd6},
    // R6 odd, odd LSB kept
    '{3'd5, 1'b1, 13'h400, 52'h5, 10'h3FF, 11'h400, 52'h5, 3'b001, 8'd6},
    // R6 odd, exact
    '{3'd5, 1'b0, 13'h400, 52'h4, 10'h000, 11'h400, 52'h4, 3'b000, 8'd6},
    // R7 carry renormalise
    '{3'd0, 1'b0, 13'h3FF, ONES,   10'h200, 11'h400, 52'h0, 3'b001, 8'd7},
    // R8 carry into overflow, nearest gives infinity
    '{3'd0, 1'b0, 13'h7FE, ONES,   10'h3FF, 11'h7FF, 52'h0, 3'b101, 8'd8},
    // R8 toward zero saturates
    '{3'd3, 1'b1, 13'h7FF, 52'h0,  10'h000, 11'h7FE, ONES, 3'b101, 8'd8},
    // R8 odd saturates
    '{3'd5, 1'b0, 13'h800, 52'h0,  10'h000, 11'h7FE, ONES, 3'b101, 8'd8},
    // R8 up, positive to infinity
    '{3'd2, 1'b0, 13'h900, 52'h0,  10'h000, 11'h7FF, 52'h0, 3'b101, 8'd8},
    // R8 down, positive saturates
    '{3'd1, 1'b0, 13'h7FF, 52'h0,  10'h000, 11'h7FE, ONES, 3'b101, 8'd8},
    // R8 down, negative to infinity
    '{3'd1, 1'b1, 13'h7FF, 52'h0,  10'h000, 11'h7FF, 52'h0, 3'b101, 8'd8},
    // R8 up, negative saturates
    '{3'd2, 1'b1, 13'h7FF, 52'h0,  10'h000, 11'h7FE, ONES, 3'b101, 8'd8},
    // R9 exponent zero flushes
    '{3'd0, 1'b1, 13'h000, 52'h3,  10'h000, 11'h000, 52'h0, 3'b011, 8'd9},
    // R9 negative exponent flushes
    '{3'd3, 1'b0, 13'h1FF0, 52'h0, 10'h000, 11'h000, 52'h0, 3'b011, 8'd9},
    // R9 carry lifts exponent 0 to 1, no flush
    '{3'd2, 1'b0, 13'h000, ONES,   10'h001, 11'h001, 52'h0, 3'b001, 8'd9},
    // R3 reserved code 6 as nearest-even; R10 style flags
    '{3'd6, 1'b0, 13'h400, 52'h5,  10'h200, 11'h400, 52'h6, 3'b001, 8'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_sign = 1'b0;
  logic signed [12:0] in_exp = '0;
  logic [62:0] in_sig = '0;
  logic [2:0] in_mode = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [63:0] out_word;
  logic out_ovf, out_unf, out_inx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_round_pack u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
  );

  task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_mode  = v.mode;
    in_sign  = v.sgn;
    in_exp   = v.ex;
    in_sig   = {1'b1, v.f, v.g};
  endtask

  function automatic logic [66:0] expect_of(input vec_t v);
    return {v.sgn, v.we, v.wf, v.fl};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: output empty during reset
    check("R11", {66'b0, out_valid}, 67'b0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    // R1: ready when empty
    check("R1", {66'b0, in_ready}, 67'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec%0d", VT[i].req, i),
            {out_valid ? {out_word, out_ovf, out_unf, out_inx} : 67'h0},
            expect_of(VT[i]));
    end

    // R1: back-pressure holds result and stalls input
    @(negedge clk);
    out_ready = 1'b0;
    drive(VT[2]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VT[5]);
    check("R1 stall ready", {66'b0, in_ready}, 67'b0);
    @(negedge clk);
    @(negedge clk);
    check("R1 stall hold", {out_word, out_ovf, out_unf, out_inx}, expect_of(VT[2]));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 next after drain", {out_word, out_ovf, out_unf, out_inx}, expect_of(VT[5]));
    @(negedge clk);
    check("R1 empty", {66'b0, out_valid}, 67'b0);

    // R10: exact at smallest normal exponent
    drive('{3'd0, 1'b0, 13'h001, 52'h0, 10'h000, 11'h001, 52'h0, 3'b000, 8'd10});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 min exact", {out_word, out_ovf, out_unf, out_inx},
          {1'b0, 11'h001, 52'h0, 3'b000});

    // R11: reset mid-stream clears valid
    out_ready = 1'b0;
    drive(VT[0]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 mid reset", {66'b0, out_valid}, 67'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule